// File: doc/BRIEF.md
# Signed Four-Operation Adder with Sign-Magnitude Display

This block is a purely combinational arithmetic unit for small two's complement numbers. It takes two signed operands and a two-bit operation code. It then forms either the sum, the increment, a pass-through copy or the difference of the operands. The second adder input comes from an operand mux, and a ripple chain of one-bit full adders produces the result.

Around the adder, the block decides whether the true mathematical result fits the signed range. It raises an overflow indicator when it does not. It also drives a negative flag that is only valid for in-range results. Two active-low seven-segment codes show the result in sign-and-magnitude form: one digit holds a minus sign and the other holds the absolute value. Both digits go dark on overflow. A host wires the outputs directly to a pair of display digits and an indicator lamp.

Top module: `signed_alu_disp`

## Requirements
- R1: With op_i = 2'b00, result_o equals (x_i + y_i) modulo 16.
- R2: With op_i = 2'b01, result_o equals (x_i + 1) modulo 16.
- R3: With op_i = 2'b10, result_o equals x_i and ovf_o is low.
- R4: With op_i = 2'b11, result_o equals (x_i − y_i) modulo 16, formed by adding the bitwise inverse of y_i with a carry-in of one.
- R5: ovf_o is high exactly when the true signed result of the selected operation lies outside −8..+7.
- R6: neg_o is high exactly when the true signed result is negative and ovf_o is low.
- R7: sign_seg_o is 7'h3F (minus, only segment g lit) when neg_o is high, and 7'h7F (blank) otherwise. Segment bits are {g,f,e,d,c,b,a}, active low.
- R8: When ovf_o is low, mag_seg_o shows the absolute value of the signed result, with −8 shown as 8. The active-low codes are 0=40, 1=79, 2=24, 3=30, 4=19, 5=12, 6=02, 7=78, 8=00 (hex).
- R9: When ovf_o is high, both sign_seg_o and mag_seg_o are 7'h7F.
- R10: Subtracting −8 overflows for every non-negative x_i and is in range for every negative x_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | 4 | First signed operand |
| y_i | input | 4 | Second signed operand |
| op_i | input | 2 | Operation: 00 add, 01 increment, 10 pass, 11 subtract |
| result_o | output | 4 | Adder sum bits (wrapped) |
| ovf_o | output | 1 | Signed overflow indicator |
| neg_o | output | 1 | In-range negative result |
| sign_seg_o | output | 7 | Sign digit, active-low {g..a} |
| mag_seg_o | output | 7 | Magnitude digit, active-low {g..a} |

## Verification
Two functions compete in the same evaluation. A sum bit pattern with its top bit set is either a genuine negative value or an overflowed wrap, and the display must pick the right reading. The sweep covers every operand pair under every opcode, so each pattern with the top bit set arises both from in-range negatives and from overflows. An integer model computes the unbounded result and judges the flag, the sign digit and the magnitude digit from it. Directed checks on subtracting −8 pin the case where inverting the subtrahend alone cannot represent the negation.

// File: rtl/signed_alu_pkg.sv
package signed_alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_INC  = 2'b01,
    OP_PASS = 2'b10,
    OP_SUB  = 2'b11
  } alu_op_e;

  localparam int SEG_W = 7;
  localparam logic [SEG_W-1:0] SEG_BLANK = 7'h7F;
  localparam logic [SEG_W-1:0] SEG_MINUS = 7'h3F;

  // active-low digit code, bit order {g,f,e,d,c,b,a}
  function automatic logic [SEG_W-1:0] seg_digit(input int unsigned d);
    logic [SEG_W-1:0] on;
    case (d)
      0: on = 7'h3F;
      1: on = 7'h06;
      2: on = 7'h5B;
      3: on = 7'h4F;
      4: on = 7'h66;
      5: on = 7'h6D;
      6: on = 7'h7D;
      7: on = 7'h07;
      8: on = 7'h7F;
      9: on = 7'h6F;
      default: on = '0;
    endcase
    return ~on;
  endfunction
endpackage

// File: rtl/full_adder.sv
module full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = a_i ^ b_i ^ c_i;
  assign c_o = (a_i & b_i) | (c_i & (a_i ^ b_i));
endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_msb_o,
  output logic         cout_o
);
  logic [W:0] carry;
  assign carry[0] = cin_i;

  for (genvar k = 0; k < W; k++) begin : g_bit
    full_adder fa_i (
      .a_i(a_i[k]),
      .b_i(b_i[k]),
      .c_i(carry[k]),
      .s_o(sum_o[k]),
      .c_o(carry[k+1])
    );
  end

  assign c_msb_o = carry[W-1];
  assign cout_o  = carry[W];
endmodule

// File: rtl/operand_mux.sv
module operand_mux
  import signed_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] b_o,
  output logic         cin_o
);
  always_comb begin
    unique case (op_i)
      OP_ADD:  b_o = y_i;
      OP_INC:  b_o = W'(1);
      OP_PASS: b_o = '0;
      OP_SUB:  b_o = ~y_i;
      default: b_o = '0;
    endcase
  end

  assign cin_o = (op_i == OP_SUB);
endmodule

// File: rtl/sign_mag_display.sv
module sign_mag_display
  import signed_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]     sum_i,
  input  logic             ovf_i,
  output logic             neg_o,
  output logic [SEG_W-1:0] sign_seg_o,
  output logic [SEG_W-1:0] mag_seg_o
);
  logic [W-1:0] mag;

  assign neg_o = sum_i[W-1] & ~ovf_i;
  // most negative value negates to itself; read unsigned it is the magnitude
  assign mag   = sum_i[W-1] ? (~sum_i + W'(1)) : sum_i;

  always_comb begin
    if (ovf_i) begin
      sign_seg_o = SEG_BLANK;
      mag_seg_o  = SEG_BLANK;
    end else begin
      sign_seg_o = neg_o ? SEG_MINUS : SEG_BLANK;
      mag_seg_o  = seg_digit(int'(mag));
    end
  end
endmodule

// File: rtl/signed_alu_disp.sv
module signed_alu_disp
  import signed_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]     x_i,
  input  logic [W-1:0]     y_i,
  input  logic [1:0]       op_i,
  output logic [W-1:0]     result_o,
  output logic             ovf_o,
  output logic             neg_o,
  output logic [SEG_W-1:0] sign_seg_o,
  output logic [SEG_W-1:0] mag_seg_o
);
  logic [W-1:0] b_op;
  logic         cin;
  logic         c_msb;
  logic         cout;

  operand_mux #(.W(W)) mux_i (
    .op_i (alu_op_e'(op_i)),
    .y_i  (y_i),
    .b_o  (b_op),
    .cin_o(cin)
  );

  ripple_adder #(.W(W)) add_i (
    .a_i    (x_i),
    .b_i    (b_op),
    .cin_i  (cin),
    .sum_o  (result_o),
    .c_msb_o(c_msb),
    .cout_o (cout)
  );

  assign ovf_o = c_msb ^ cout;

  sign_mag_display #(.W(W)) disp_i (
    .sum_i     (result_o),
    .ovf_i     (ovf_o),
    .neg_o     (neg_o),
    .sign_seg_o(sign_seg_o),
    .mag_seg_o (mag_seg_o)
  );
endmodule

// File: rtl/signed_alu_disp_chk.sv
module signed_alu_disp_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] x_i,
  input logic [W-1:0] y_i,
  input logic [1:0]   op_i,
  input logic [W-1:0] result_o,
  input logic         ovf_o,
  input logic         neg_o,
  input logic [6:0]   sign_seg_o,
  input logic [6:0]   mag_seg_o
);
  always_comb begin
    a_r3_pass_through: assert (op_i != 2'b10 || (result_o == x_i && !ovf_o));
    a_r2_inc_ovf: assert (op_i != 2'b01 ||
                          ovf_o == (x_i == {1'b0, {(W-1){1'b1}}}));
    a_r1_add_ovf: assert (op_i != 2'b00 || x_i[W-1] != y_i[W-1] || !ovf_o
                          || result_o[W-1] != x_i[W-1]);
    a_r6_neg_not_ovf: assert (!(neg_o && ovf_o));
    a_r7_sign_digit: assert (sign_seg_o == (neg_o ? 7'h3F : 7'h7F));
    a_r9_blank: assert (!ovf_o || (sign_seg_o == 7'h7F && mag_seg_o == 7'h7F));
    a_r8_mag_lit: assert (ovf_o || mag_seg_o != 7'h7F);
    a_r10_sub_min: assert (!(op_i == 2'b11 && y_i == {1'b1, {(W-1){1'b0}}})
                           || ovf_o == !x_i[W-1]);
  end
endmodule

bind signed_alu_disp signed_alu_disp_chk #(.W(W)) chk_i (
  .x_i(x_i), .y_i(y_i), .op_i(op_i), .result_o(result_o), .ovf_o(ovf_o),
  .neg_o(neg_o), .sign_seg_o(sign_seg_o), .mag_seg_o(mag_seg_o)
);

// File: tb/signed_alu_disp_tb_top.sv
module signed_alu_disp_tb_top;
  logic       clk = 1'b0;
  logic [3:0] x, y, res;
  logic [1:0] op;
  logic       ovf, neg;
  logic [6:0] sseg, mseg;
  int         n_chk = 0;
  int         n_fail = 0;
  int         cycles = 0;

  always #10 clk = ~clk;

  signed_alu_disp dut_i (
    .x_i(x), .y_i(y), .op_i(op), .result_o(res), .ovf_o(ovf),
    .neg_o(neg), .sign_seg_o(sseg), .mag_seg_o(mseg)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [6:0] digit(input int d);
    case (d)
      0: return 7'h40; 1: return 7'h79; 2: return 7'h24;
      3: return 7'h30; 4: return 7'h19; 5: return 7'h12;
      6: return 7'h02; 7: return 7'h78; 8: return 7'h00;
      default: return 7'h7F;
    endcase
  endfunction

  function automatic string op_tag(input logic [1:0] o);
    case (o)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s x=%0d y=%0d op=%0d: actual %0h expected %0h",
               tag, x, y, op, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] o, input logic [3:0] a, input logic [3:0] b);
    int sa, sb, t, m;
    bit e_ovf, e_neg;
    @(posedge clk);
    op = o; x = a; y = b;
    @(negedge clk);
    sa = $signed(a); sb = $signed(b);
    case (o)
      2'b00: t = sa + sb;
      2'b01: t = sa + 1;
      2'b10: t = sa;
      default: t = sa - sb;
    endcase
    e_ovf = (t < -8) || (t > 7);
    e_neg = !e_ovf && (t < 0);
    m = (t < 0) ? -t : t;
    chk(op_tag(o), int'(res), t & 15);
    chk("R5", int'(ovf), int'(e_ovf));
    chk("R6", int'(neg), int'(e_neg));
    if (e_ovf) begin
      chk("R9 sign", int'(sseg), 'h7F);
      chk("R9 mag", int'(mseg), 'h7F);
    end else begin
      chk("R7", int'(sseg), e_neg ? 'h3F : 'h7F);
      chk("R8", int'(mseg), int'(digit(m)));
    end
  endtask

  initial begin
    x = '0; y = '0; op = '0;
    // idle inputs: zero result, blank sign, digit 0
    @(negedge clk);
    chk("R1 idle", int'(res), 0);
    chk("R7 idle", int'(sseg), 'h7F);
    chk("R8 idle", int'(mseg), 'h40);
    // directed corners
    apply(2'b11, 4'h0, 4'h8);                 // 0 - (-8): overflow
    chk("R10 ovf", int'(ovf), 1);
    apply(2'b11, 4'hF, 4'h8);                 // -1 - (-8) = 7
    chk("R10 ok", int'(mseg), 'h78);
    apply(2'b10, 4'h8, 4'h3);                 // -8 shown as 8
    chk("R8 min", int'(mseg), 'h00);
    chk("R7 min", int'(sseg), 'h3F);
    apply(2'b01, 4'h7, 4'h0);                 // 7 + 1 overflows
    chk("R2 ovf", int'(ovf), 1);
    // exhaustive sweep
    for (int o = 0; o < 4; o++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          apply(2'(o), 4'(a), 4'(b));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule